// File: doc/BRIEF.md
# PS/2 Receiver with Error Timeouts

This block receives frames from a PS/2 device over a two-wire open-drain link. The clock and data lines first pass a two-flop synchronizer and a short glitch filter. Data is then sampled on each falling clock edge and built into an 11-bit frame: a start bit of 0, eight data bits with the least significant bit first, a parity bit and a stop bit of 1. The parity bit is checked as odd or even, or it is not checked. The stop bit is checked for framing. Two timers run from a microsecond tick, which a parameterized divider derives from the system clock. One limits the gap between falling edges. The other limits the span from the start-bit edge to the parity-bit edge.

A good frame sets a data-ready flag and loads the byte into the receive register. A parity error, a framing error or a timing error sets its own flag, where one exists, together with a shared receive-timeout flag. The timeout flag makes the block pull the clock line low, which stops the device from sending. The clock is released only when two conditions are both met: a minimum hold time has passed, and a status read strobe has been seen. The two may occur in either order. Reading the receive register clears data-ready. The error flags clear when a 1 is written to them. A one-cycle activity interrupt marks each 0-to-1 change of data-ready or receive-timeout.

Top module: `kbd_link_rx`

## Requirements
- R1: `parity_mode_i` selects the parity check: 2'b01 is odd, 2'b10 is even, and 2'b00 or 2'b11 means no check. When parity is checked and the 10th falling edge carries the wrong parity bit, status bit 2 (parity error) and status bit 1 (receive timeout) are both set, and no byte is loaded. When no check is made, the parity bit has no effect.
- R2: Inside a frame, a gap of more than BIT_TMO_US microseconds between falling edges sets status bit 1 and abandons the frame.
- R3: If more than FRAME_TMO_US microseconds pass from the start-bit edge before the 10th edge arrives, status bit 1 is set and the frame is abandoned. A frame that finishes inside this limit is accepted.
- R4: A stop bit of 0 at the 11th edge sets status bit 3 (framing error) and status bit 1.
- R5: While status bit 1 is being set, `kb_clk_pull_o` goes high. It stays high until at least HOLD_US microseconds have passed and a `status_rd_i` strobe has arrived after the error. Either of the two may come first.
- R6: After the 11th edge of a frame with no error, status bit 0 (data ready) is set and `rdata_o` holds the eight data bits, with the first data bit received in bit 0.
- R7: A `rdata_rd_i` strobe clears status bit 0. A `status_wr_i` strobe clears each of status bits 3..1 whose bit in `status_clr_i` is 1. A 0 in the mask leaves that flag unchanged.
- R8: `irq_o` pulses for one cycle when status bit 0 or status bit 1 changes from 0 to 1. A new good frame that arrives while data-ready is still set gives no pulse.
- R9: While `en_i` is low, no new frame begins. If `en_i` drops before the 10th edge, the frame is dropped and no flag is set. If `en_i` drops after the 10th edge, the frame still completes and sets data ready.
- R10: A first edge that carries a data value of 1 is treated as noise. No flag is set and the line is not pulled.
- R11: After reset, the status is 0, the clock line is not pulled and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| parity_mode_i | input | 2 | Parity check select |
| kb_clk_i | input | 1 | Sensed level of the link clock line |
| kb_data_i | input | 1 | Sensed level of the link data line |
| kb_clk_pull_o | output | 1 | High while the block pulls the clock line low |
| status_rd_i | input | 1 | One-cycle strobe: status has been read |
| status_wr_i | input | 1 | One-cycle strobe: clear the error flags set in the mask |
| status_clr_i | input | 3 | Clear mask, aligned to status bits 3..1 |
| rdata_rd_i | input | 1 | One-cycle strobe: receive register has been read |
| status_o | output | 4 | {framing err, parity err, rx timeout, data ready} |
| rdata_o | output | 8 | Last byte received correctly |
| irq_o | output | 1 | One-cycle activity interrupt |

## Verification
The assertions assume three things about the inputs. The link lines are held stable for longer than the filter length around each transition. Software strobes last one cycle. `en_i` changes only between link edges. The bench meets these conditions. It settles data half a bit period before each falling edge, and it uses bit periods far longer than the filter and synchronizer delay. It drives every strobe and enable change on the falling system clock edge. The bench models the clock line as wired-AND, combining the device with the block's pull, so inhibited edges never reach the receiver.

// File: rtl/kbd_rx_pkg.sv
`timescale 1ns/1ps
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  localparam int ST_RDY = 0;
  localparam int ST_TMO = 1;
  localparam int ST_PE  = 2;
  localparam int ST_FE  = 3;

  typedef struct packed {
    logic ok;
    logic pe;
    logic fe;
    logic tmo;
  } rx_evt_t;
endpackage

// File: rtl/kbd_rx_tick.sv
`timescale 1ns/1ps
module kbd_rx_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = $clog2(CLK_PER_US + 1);
  localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/kbd_rx_sync.sv
`timescale 1ns/1ps
module kbd_rx_sync #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]          meta_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                filt_q, filt_d;

  assign line_o = filt_q;

  always_comb begin
    filt_d = filt_q;
    if (&hist_q)       filt_d = 1'b1;
    else if (~|hist_q) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      meta_q <= {meta_q[0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], meta_q[1]};
      filt_q <= filt_d;
    end
  end
endmodule

// File: rtl/kbd_rx_frame.sv
`timescale 1ns/1ps
module kbd_rx_frame
  import kbd_rx_pkg::*;
#(
  parameter int BIT_TMO_US   = 300,
  parameter int FRAME_TMO_US = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       inhibit_i,
  input  logic [1:0] par_mode_i,
  input  logic       clk_f_i,
  input  logic       dat_f_i,
  output rx_evt_t    evt_o,
  output logic [7:0] byte_o
);
  localparam int BW = $clog2(BIT_TMO_US + 1);
  localparam int FW = $clog2(FRAME_TMO_US + 1);
  localparam logic [BW-1:0] BIT_LIM = BW'(BIT_TMO_US);
  localparam logic [FW-1:0] FRM_LIM = FW'(FRAME_TMO_US);

  logic          busy_q, busy_d;
  logic [3:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          cprev_q;
  logic [BW-1:0] gap_q, gap_d;
  logic [FW-1:0] span_q, span_d;
  logic          fall, xp, par_bad;

  assign fall    = cprev_q & ~clk_f_i;
  assign xp      = (^sh_q) ^ dat_f_i;
  assign par_bad = (par_mode_i == PAR_ODD  && !xp) ||
                   (par_mode_i == PAR_EVEN &&  xp);
  assign byte_o  = sh_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    gap_d  = gap_q;
    span_d = span_q;
    evt_o  = '0;
    if (!busy_q) begin
      if (fall && en_i && !inhibit_i && !dat_f_i) begin
        busy_d = 1'b1;
        idx_d  = 4'd1;
        gap_d  = '0;
        span_d = '0;
      end
    end else if (!en_i && idx_q < 4'd10) begin
      busy_d = 1'b0;
    end else begin
      if (tick_i) begin
        gap_d = gap_q + 1'b1;
        if (idx_q < 4'd10) span_d = span_q + 1'b1;
      end
      if (fall) begin
        gap_d = '0;
        if (idx_q < 4'd9) begin
          sh_d  = {dat_f_i, sh_q[7:1]};
          idx_d = idx_q + 4'd1;
        end else if (idx_q == 4'd9) begin
          if (par_bad) begin
            evt_o.pe = 1'b1;
            busy_d   = 1'b0;
          end else begin
            idx_d = 4'd10;
          end
        end else begin
          if (dat_f_i) evt_o.ok = 1'b1;
          else         evt_o.fe = 1'b1;
          busy_d = 1'b0;
        end
      end else if (tick_i && gap_q == BIT_LIM) begin
        evt_o.tmo = 1'b1;
        busy_d    = 1'b0;
      end else if (tick_i && idx_q < 4'd10 && span_q == FRM_LIM) begin
        evt_o.tmo = 1'b1;
        busy_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      cprev_q <= 1'b1;
      gap_q   <= '0;
      span_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      cprev_q <= clk_f_i;
      gap_q   <= gap_d;
      span_q  <= span_d;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_o)); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q >= 4'd1 && idx_q <= 4'd10)); // R6
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> gap_q <= BIT_LIM); // R2
  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q < 4'd10) |-> span_q <= FRM_LIM); // R3
endmodule

// File: rtl/kbd_link_rx.sv
`timescale 1ns/1ps
module kbd_link_rx
  import kbd_rx_pkg::*;
#(
  parameter int CLK_PER_US   = 125,
  parameter int FILT_LEN     = 3,
  parameter int BIT_TMO_US   = 300,
  parameter int FRAME_TMO_US = 2000,
  parameter int HOLD_US      = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] parity_mode_i,
  input  logic       kb_clk_i,
  input  logic       kb_data_i,
  output logic       kb_clk_pull_o,
  input  logic       status_rd_i,
  input  logic       status_wr_i,
  input  logic [3:1] status_clr_i,
  input  logic       rdata_rd_i,
  output logic [3:0] status_o,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int HW = $clog2(HOLD_US + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD_US);

  logic       tick;
  logic [1:0] raw_lines, filt_lines;
  rx_evt_t    evt;
  logic [7:0] rx_byte;
  logic       err;

  logic rdy_q, rdy_d, tmo_q, tmo_d, pe_q, pe_d, fe_q, fe_d, irq_q, irq_d;
  logic [7:0] rdata_q, rdata_d;
  logic          hold_q, hold_d, seen_q, seen_d;
  logic [HW-1:0] hcnt_q, hcnt_d;

  assign raw_lines = {kb_data_i, kb_clk_i};

  kbd_rx_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar g = 0; g < 2; g++) begin : g_line
    kbd_rx_sync #(.FILT_LEN(FILT_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g])
    );
  end

  kbd_rx_frame #(.BIT_TMO_US(BIT_TMO_US), .FRAME_TMO_US(FRAME_TMO_US)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en_i), .inhibit_i(hold_q),
    .par_mode_i(parity_mode_i), .clk_f_i(filt_lines[0]), .dat_f_i(filt_lines[1]),
    .evt_o(evt), .byte_o(rx_byte)
  );

  assign err = evt.pe | evt.fe | evt.tmo;

  always_comb begin
    rdy_d = rdy_q;
    if (rdata_rd_i) rdy_d = 1'b0;
    if (evt.ok)     rdy_d = 1'b1;
    tmo_d = tmo_q;
    pe_d  = pe_q;
    fe_d  = fe_q;
    if (status_wr_i) begin
      if (status_clr_i[ST_TMO]) tmo_d = 1'b0;
      if (status_clr_i[ST_PE])  pe_d  = 1'b0;
      if (status_clr_i[ST_FE])  fe_d  = 1'b0;
    end
    if (err)    tmo_d = 1'b1;
    if (evt.pe) pe_d  = 1'b1;
    if (evt.fe) fe_d  = 1'b1;
    rdata_d = evt.ok ? rx_byte : rdata_q;
    irq_d   = (evt.ok & ~rdy_q) | (err & ~tmo_q);
  end

  always_comb begin
    hold_d = hold_q;
    hcnt_d = hcnt_q;
    seen_d = seen_q;
    if (err) begin
      hold_d = 1'b1;
      hcnt_d = '0;
      seen_d = 1'b0;
    end else if (hold_q) begin
      if (tick && hcnt_q < HOLD_LIM) hcnt_d = hcnt_q + 1'b1;
      if (status_rd_i) seen_d = 1'b1;
      if (hcnt_q == HOLD_LIM && (seen_q || status_rd_i)) hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      tmo_q   <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
      hold_q  <= 1'b0;
      hcnt_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      rdy_q   <= rdy_d;
      tmo_q   <= tmo_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      irq_q   <= irq_d;
      rdata_q <= rdata_d;
      hold_q  <= hold_d;
      hcnt_q  <= hcnt_d;
      seen_q  <= seen_d;
    end
  end

  assign status_o      = {fe_q, pe_q, tmo_q, rdy_q};
  assign rdata_o       = rdata_q;
  assign irq_o         = irq_q;
  assign kb_clk_pull_o = hold_q;

  AST_TMO_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> kb_clk_pull_o); // R5
  AST_PULL_NEEDS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kb_clk_pull_o) |-> tmo_q); // R5
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_clk_pull_o) |-> $past(hcnt_q) == HOLD_LIM); // R5
  AST_PE_SETS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_q) |-> tmo_q); // R1
  AST_FE_SETS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_q) |-> tmo_q); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($rose(rdy_q) || $rose(tmo_q))); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8
endmodule

// File: tb/kbd_link_rx_bench.sv
`timescale 1ns/1ps
module kbd_link_rx_bench;
  localparam int US = 32;  // 4 clocks of 8 ns

  logic       clk, rst_n, en, status_rd, status_wr, rdata_rd;
  logic [1:0] pmode;
  logic [3:1] clr;
  logic       dev_clk, dev_dat, pull, irq;
  logic [3:0] status;
  logic [7:0] rdata;
  wire        line_clk = dev_clk & ~pull;

  int checks, failures, irq_cnt, cyc;
  bit done;

  kbd_link_rx #(.CLK_PER_US(4), .FILT_LEN(3), .BIT_TMO_US(30),
                .FRAME_TMO_US(200), .HOLD_US(30)) u_kbd_link_rx (
    .clk(clk), .rst_n(rst_n), .en_i(en), .parity_mode_i(pmode),
    .kb_clk_i(line_clk), .kb_data_i(dev_dat), .kb_clk_pull_o(pull),
    .status_rd_i(status_rd), .status_wr_i(status_wr), .status_clr_i(clr),
    .rdata_rd_i(rdata_rd), .status_o(status), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [7:0] b);
    return ~(^b);
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic pb, input logic stop,
                            input logic start, input int half_us, input int drop_at,
                            input int stall_at);
    logic [10:0] bits;
    bits = {stop, pb, b, start};
    for (int i = 0; i < 11; i++) begin
      if (stall_at == i + 1) begin
        #(40 * US);
        dev_dat = 1'b1;
        #(3 * US);
        return;
      end
      dev_dat = bits[i];
      #(half_us * US);
      dev_clk = 1'b0;
      #(half_us * US);
      dev_clk = 1'b1;
      if (drop_at == i + 1) en = 1'b0;
    end
    dev_dat = 1'b1;
    #(3 * US);
  endtask

  task automatic pulse_status_rd();
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
  endtask

  task automatic pulse_rdata_rd();
    @(negedge clk) rdata_rd = 1'b1;
    @(negedge clk) rdata_rd = 1'b0;
  endtask

  task automatic write_clr(input logic [3:1] m);
    @(negedge clk) begin status_wr = 1'b1; clr = m; end
    @(negedge clk) begin status_wr = 1'b0; clr = '0; end
  endtask

  task automatic recover();
    pulse_status_rd();
    #(35 * US);
    write_clr(3'b111);
    @(negedge clk);
    chk("R5 recover pull", pull, 1'b0);
    chk("R7 recover status", status, 4'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 status", status, 4'h0);
    chk("R11 pull", pull, 1'b0);
    chk("R11 irq", irq, 1'b0);
  endtask

  task automatic t_good_frames();
    int base;
    base = irq_cnt;
    pmode = 2'b01;
    send_frame(8'hA5, odd_bit(8'hA5), 1'b1, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R6 ready", status, 4'h1);
    chk("R6 data", rdata, 8'hA5);
    chk("R8 one irq", irq_cnt - base, 1);
    chk("R1 odd accepted pull", pull, 1'b0);
    send_frame(8'h3C, odd_bit(8'h3C), 1'b1, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R6 second data", rdata, 8'h3C);
    chk("R8 no irq while ready", irq_cnt - base, 1);
    pulse_rdata_rd();
    @(negedge clk);
    chk("R7 rdata read clears ready", status, 4'h0);
  endtask

  task automatic t_parity_error();
    int base;
    base = irq_cnt;
    pmode = 2'b10;
    send_frame(8'h0F, 1'b1, 1'b1, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R1 even mismatch flags", status, 4'h6);
    chk("R1 data kept", rdata, 8'h3C);
    chk("R5 pulled", pull, 1'b1);
    chk("R8 irq on timeout", irq_cnt - base, 1);
    #(40 * US);
    @(negedge clk);
    chk("R5 held without read", pull, 1'b1);
    pulse_status_rd();
    #(2 * US);
    @(negedge clk);
    chk("R5 released after read", pull, 1'b0);
    write_clr(3'b000);
    @(negedge clk);
    chk("R7 zero mask keeps", status, 4'h6);
    write_clr(3'b010);
    @(negedge clk);
    chk("R7 clear pe only", status, 4'h2);
    write_clr(3'b001);
    @(negedge clk);
    chk("R7 clear timeout", status, 4'h0);
  endtask

  task automatic t_parity_off();
    pmode = 2'b00;
    send_frame(8'h81, odd_bit(8'h81), 1'b1, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R1 ignored parity ready", status, 4'h1);
    chk("R1 ignored parity data", rdata, 8'h81);
    pulse_rdata_rd();
  endtask

  task automatic t_framing();
    pmode = 2'b01;
    send_frame(8'h5A, odd_bit(8'h5A), 1'b0, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R4 framing flags", status, 4'hA);
    pulse_status_rd();
    #(10 * US);
    @(negedge clk);
    chk("R5 held for minimum", pull, 1'b1);
    #(30 * US);
    @(negedge clk);
    chk("R5 released read first", pull, 1'b0);
    write_clr(3'b111);
  endtask

  task automatic t_bit_timeout();
    pmode = 2'b00;
    send_frame(8'h12, 1'b0, 1'b1, 1'b0, 8, 0, 6);
    @(negedge clk);
    chk("R2 gap timeout", status, 4'h2);
    chk("R2 pulled", pull, 1'b1);
    recover();
  endtask

  task automatic t_frame_timeout();
    pmode = 2'b00;
    send_frame(8'h44, 1'b0, 1'b1, 1'b0, 12, 0, 0);
    @(negedge clk);
    chk("R3 span timeout", status, 4'h2);
    recover();
    send_frame(8'h44, 1'b0, 1'b1, 1'b0, 10, 0, 0);
    @(negedge clk);
    chk("R3 inside span ready", status, 4'h1);
    chk("R3 inside span data", rdata, 8'h44);
    pulse_rdata_rd();
  endtask

  task automatic t_enable();
    pmode = 2'b00;
    @(negedge clk) en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b1, 1'b0, 8, 0, 0);
    @(negedge clk);
    chk("R9 disabled ignores", status, 4'h0);
    chk("R9 disabled data", rdata, 8'h44);
    en = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b1, 1'b0, 8, 10, 0);
    @(negedge clk);
    chk("R9 late disable completes", status, 4'h1);
    chk("R9 late disable data", rdata, 8'hC3);
    pulse_rdata_rd();
    en = 1'b1;
    send_frame(8'h99, 1'b0, 1'b1, 1'b0, 8, 5, 0);
    @(negedge clk);
    chk("R9 early disable drops", status, 4'h0);
    chk("R9 early disable pull", pull, 1'b0);
    en = 1'b1;
  endtask

  task automatic t_noise_start();
    pmode = 2'b01;
    send_frame(8'hFF, odd_bit(8'hFF), 1'b1, 1'b1, 8, 0, 0);
    @(negedge clk);
    chk("R10 noise no flags", status, 4'h0);
    chk("R10 noise no pull", pull, 1'b0);
  endtask

  initial begin
    checks = 0; failures = 0; irq_cnt = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b1; pmode = 2'b00;
    status_rd = 1'b0; status_wr = 1'b0; clr = '0; rdata_rd = 1'b0;
    dev_clk = 1'b1; dev_dat = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_good_frames();
    t_parity_error();
    t_parity_off();
    t_framing();
    t_bit_timeout();
    t_frame_timeout();
    t_enable();
    t_noise_start();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule